// File: doc/BRIEF.md
# Non-volatile Configuration Image Loader

The loader sits above a word-wide request/response port that reaches a 64-word, 16-bit serial configuration memory. After reset, and again whenever it is asked, it fetches every word in ascending address order into an internal shadow array. While the words arrive it keeps a 16-bit wraparound sum. At the end it decides whether the image is usable. The image is usable only when that sum hits a fixed target and a masked signature field in an initialization control word holds the expected pattern.

A repair mode fetches words 0 to 62 and computes the word that brings the total to the target. It writes that word to address 63, then judges the image as a load would. Word lookups are served from the shadow and return zero whenever the image is unusable or the index is out of range. A lookup that arrives while the image is unusable first triggers a full reload. A lookup that arrives during a load is held off until the load completes. A 32-bit board number is formed from two shadow words.

The controller is one state machine with these states:
- S_BOOT: the reset state, which starts the first load.
- S_IDLE: waits for requests.
- S_READ: fetches the word at the current address.
- S_WRITE: stores the repaired checksum word.
- S_JUDGE: decides validity.
- S_REPLY: answers one lookup.

The transitions are:
- BOOT→READ.
- IDLE→READ on an update request, a load request, or a lookup that needs a reload.
- IDLE→REPLY on a lookup served directly.
- READ→READ after each word except the last.
- READ→WRITE after word 62 in repair mode.
- READ→JUDGE after word 63 in load mode.
- WRITE→JUDGE when the write is acknowledged.
- JUDGE→REPLY when a lookup is pending, otherwise JUDGE→IDLE.
- REPLY→IDLE.

Top module: `nvm_image_loader`

## Requirements
- R1: Releasing reset starts a load without any request. The block reads addresses 0,1,...,63 in strictly ascending order, once each. `busy` is high from the reset state until the verdict is written.
- R2: When a load ends, the image is valid only if the 16-bit wraparound sum of all 64 words equals 0xBABA. A mismatch sets `cksum_err` and leaves `valid` low.
- R3: An update request reads words 0 to 62 only. It then performs exactly one write, to address 63, with data 0xBABA minus their 16-bit sum. After that write the image is judged, and it is valid when the signature matches.
- R4: The signature check is made only after the checksum passes. It requires (word[CTRL_IDX] & SIG_MASK) == SIG_VALUE, which is word 10, mask 0xC000 and value 0x4000 by default. A failure sets `sig_err`, leaves `cksum_err` low and keeps `valid` low.
- R5: A lookup is answered by a single-cycle `lk_ack` pulse. `lk_data` carries the shadow word when the 7-bit `lk_idx` is below 64 and the image is valid, and 0 otherwise.
- R6: A lookup on a valid image causes no port traffic. An in-range lookup on an invalid image first performs a full 64-word reload and then answers according to R5. An out-of-range lookup never reloads.
- R7: `board_num` is {word[PBA_HI_IDX], word[PBA_LO_IDX]}, which is word 9 in the upper half and word 8 in the lower half by default. It is 0 while the image is not valid.
- R8: `cksum_err` and `sig_err` hold their values until the next load or update begins. Both are 0, and `valid` is 0, from the first busy cycle of that load. All three are 0 in reset.
- R9: A lookup raised during a load or update is not answered while `busy` is high. It is answered after the operation ends, from the freshly judged image.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_req | input | 1 | One-cycle request for a full reload, taken when idle |
| upd_req | input | 1 | One-cycle request for checksum repair, taken when idle |
| lk_req | input | 1 | Lookup request, held until `lk_ack` |
| lk_idx | input | 7 | Lookup word index |
| lk_ack | output | 1 | One-cycle lookup answer strobe |
| lk_data | output | 16 | Lookup answer word |
| mem_req | output | 1 | Word-port request, held until `mem_ack` |
| mem_we | output | 1 | Word-port write (1) or read (0) |
| mem_addr | output | 6 | Word-port address |
| mem_wdata | output | 16 | Word-port write data |
| mem_ack | input | 1 | Word-port completion strobe |
| mem_rdata | input | 16 | Word-port read data, valid with `mem_ack` |
| busy | output | 1 | Load or update in progress |
| valid | output | 1 | Image passed checksum and signature |
| cksum_err | output | 1 | Last judgement failed the checksum |
| sig_err | output | 1 | Last judgement passed the checksum but failed the signature |
| board_num | output | 32 | Board number from two shadow words |

## Verification
A broken address counter shows up at the word port within the first few fetches, as a repeated, skipped or out-of-order address. A corrupted running sum or shadow write does not show until the verdict, about 130 cycles after the load starts. At that point `valid` and the error flags disagree with the image the bench holds. Afterwards lookups and `board_num` return wrong words. A wrong pending-lookup state shows as a reply during `busy`, a missing reply, or a reload on a lookup that should have been served directly, which appears as unexpected port traffic.

// File: rtl/nvm_ldr_pkg.sv
package nvm_ldr_pkg;

    typedef enum logic [2:0] {
        S_BOOT  = 3'd0,
        S_IDLE  = 3'd1,
        S_READ  = 3'd2,
        S_WRITE = 3'd3,
        S_JUDGE = 3'd4,
        S_REPLY = 3'd5
    } ldr_state_e;

endpackage

// File: rtl/nvm_ldr_accum.sv
// Running 16-bit wraparound sum of the words that pass through the loader.
module nvm_ldr_accum #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          add_en,
    input  logic [DW-1:0] add_val,
    output logic [DW-1:0] sum
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            sum <= '0;
        end else if (add_en) begin
            sum <= sum + add_val;
        end
    end
endmodule

// File: rtl/nvm_ldr_shadow.sv
// Shadow copy of the image: one write port, NRD combinational read ports.
module nvm_ldr_shadow #(
    parameter int DW    = 16,
    parameter int WORDS = 64,
    parameter int NRD   = 4,
    localparam int AW   = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DW-1:0]     wdata,
    input  logic [NRD*AW-1:0] raddr,
    output logic [NRD*DW-1:0] rdata
);
    logic [DW-1:0] store [WORDS];

    always_ff @(posedge clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    for (genvar k = 0; k < NRD; k++) begin : g_rd
        assign rdata[k*DW +: DW] = store[raddr[k*AW +: AW]];
    end
endmodule

// File: rtl/nvm_ldr_judge.sv
// Verdict logic: checksum target compare and masked signature compare.
module nvm_ldr_judge #(
    parameter int            DW         = 16,
    parameter logic [DW-1:0] CHK_TARGET = 16'hBABA,
    parameter logic [DW-1:0] SIG_MASK   = 16'hC000,
    parameter logic [DW-1:0] SIG_VALUE  = 16'h4000
) (
    input  logic [DW-1:0] sum,
    input  logic [DW-1:0] ctrl_word,
    output logic          sum_ok,
    output logic          sig_ok,
    output logic [DW-1:0] fix_word
);
    assign sum_ok   = (sum == CHK_TARGET);
    assign sig_ok   = ((ctrl_word & SIG_MASK) == SIG_VALUE);
    assign fix_word = CHK_TARGET - sum;
endmodule

// File: rtl/nvm_image_loader.sv
module nvm_image_loader #(
    parameter int            DW         = 16,
    parameter int            WORDS      = 64,
    parameter int            CTRL_IDX   = 10,
    parameter logic [DW-1:0] SIG_MASK   = 16'hC000,
    parameter logic [DW-1:0] SIG_VALUE  = 16'h4000,
    parameter logic [DW-1:0] CHK_TARGET = 16'hBABA,
    parameter int            PBA_LO_IDX = 8,
    parameter int            PBA_HI_IDX = 9,
    localparam int           AW         = $clog2(WORDS),
    localparam int           IW         = AW + 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load_req,
    input  logic            upd_req,
    input  logic            lk_req,
    input  logic [IW-1:0]   lk_idx,
    output logic            lk_ack,
    output logic [DW-1:0]   lk_data,
    output logic            mem_req,
    output logic            mem_we,
    output logic [AW-1:0]   mem_addr,
    output logic [DW-1:0]   mem_wdata,
    input  logic            mem_ack,
    input  logic [DW-1:0]   mem_rdata,
    output logic            busy,
    output logic            valid,
    output logic            cksum_err,
    output logic            sig_err,
    output logic [2*DW-1:0] board_num
);
    import nvm_ldr_pkg::*;

    localparam int            NRD     = 4;
    localparam logic [AW-1:0] LAST_A  = AW'(WORDS - 1);
    localparam logic [AW-1:0] PREV_A  = AW'(WORDS - 2);
    localparam logic [IW-1:0] LIMIT_I = IW'(WORDS);

    ldr_state_e state, nxt;

    logic [AW-1:0] addr_q;
    logic          upd_mode_q;
    logic          lk_pend_q;
    logic [IW-1:0] lk_idx_q;
    logic          valid_q, cerr_q, serr_q;

    logic          in_range, in_range_q;
    logic          idle_upd, idle_load, idle_lk, lk_needs_load;
    logic          start;
    logic          last_word;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;
    logic [DW-1:0] sum;
    logic          sum_ok, sig_ok;
    logic [DW-1:0] fix_word;

    logic [NRD*AW-1:0] rd_addr;
    logic [NRD*DW-1:0] rd_data;
    logic [DW-1:0]     rd_lk, rd_ctrl, rd_lo, rd_hi;

    // ------------------------------------------------------------------
    // request decode in S_IDLE: update wins over load, load over lookup
    // ------------------------------------------------------------------
    assign in_range      = (lk_idx < LIMIT_I);
    assign in_range_q    = (lk_idx_q < LIMIT_I);
    assign idle_upd      = (state == S_IDLE) && upd_req;
    assign idle_load     = (state == S_IDLE) && !upd_req && load_req;
    assign idle_lk       = (state == S_IDLE) && !upd_req && !load_req && lk_req;
    assign lk_needs_load = idle_lk && in_range && !valid_q;
    assign start         = (state == S_BOOT) || idle_upd || idle_load || lk_needs_load;
    assign last_word     = (addr_q == (upd_mode_q ? PREV_A : LAST_A));

    // ------------------------------------------------------------------
    // state register
    // ------------------------------------------------------------------
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_BOOT;
        end else begin
            state <= nxt;
        end
    end

    // ------------------------------------------------------------------
    // next-state logic
    // ------------------------------------------------------------------
    always_comb begin
        nxt = state;
        unique case (state)
            S_BOOT:  nxt = S_READ;
            S_IDLE: begin
                if (idle_upd || idle_load || lk_needs_load) begin
                    nxt = S_READ;
                end else if (idle_lk) begin
                    nxt = S_REPLY;
                end
            end
            S_READ: begin
                if (mem_ack && last_word) begin
                    nxt = upd_mode_q ? S_WRITE : S_JUDGE;
                end
            end
            S_WRITE: begin
                if (mem_ack) begin
                    nxt = S_JUDGE;
                end
            end
            S_JUDGE: nxt = lk_pend_q ? S_REPLY : S_IDLE;
            S_REPLY: nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    // ------------------------------------------------------------------
    // datapath registers: address, mode, pending lookup, verdict flags
    // ------------------------------------------------------------------
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q     <= '0;
            upd_mode_q <= 1'b0;
            lk_pend_q  <= 1'b0;
            lk_idx_q   <= '0;
            valid_q    <= 1'b0;
            cerr_q     <= 1'b0;
            serr_q     <= 1'b0;
        end else begin
            if (start) begin
                addr_q     <= '0;
                upd_mode_q <= idle_upd;
                lk_pend_q  <= lk_needs_load;
                valid_q    <= 1'b0;
                cerr_q     <= 1'b0;
                serr_q     <= 1'b0;
            end
            if (idle_lk) begin
                lk_idx_q <= lk_idx;
            end
            if (state == S_READ && mem_ack) begin
                addr_q <= addr_q + 1'b1;
            end
            if (state == S_JUDGE) begin
                valid_q <= sum_ok && sig_ok;
                cerr_q  <= !sum_ok;
                serr_q  <= sum_ok && !sig_ok;
            end
            if (state == S_REPLY) begin
                lk_pend_q <= 1'b0;
            end
        end
    end

    // ------------------------------------------------------------------
    // shadow fill and running sum
    // ------------------------------------------------------------------
    assign wr_en   = mem_ack && ((state == S_READ) || (state == S_WRITE));
    assign wr_addr = (state == S_WRITE) ? LAST_A : addr_q;
    assign wr_data = (state == S_WRITE) ? fix_word : mem_rdata;

    nvm_ldr_accum #(.DW(DW)) u_accum (
        .clk     (clk),
        .rst     (rst),
        .clr     (start),
        .add_en  (wr_en),
        .add_val (wr_data),
        .sum     (sum)
    );

    assign rd_addr = {AW'(PBA_HI_IDX), AW'(PBA_LO_IDX), AW'(CTRL_IDX), lk_idx_q[AW-1:0]};

    nvm_ldr_shadow #(.DW(DW), .WORDS(WORDS), .NRD(NRD)) u_shadow (
        .clk   (clk),
        .we    (wr_en),
        .waddr (wr_addr),
        .wdata (wr_data),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    assign rd_lk   = rd_data[0*DW +: DW];
    assign rd_ctrl = rd_data[1*DW +: DW];
    assign rd_lo   = rd_data[2*DW +: DW];
    assign rd_hi   = rd_data[3*DW +: DW];

    nvm_ldr_judge #(
        .DW         (DW),
        .CHK_TARGET (CHK_TARGET),
        .SIG_MASK   (SIG_MASK),
        .SIG_VALUE  (SIG_VALUE)
    ) u_judge (
        .sum       (sum),
        .ctrl_word (rd_ctrl),
        .sum_ok    (sum_ok),
        .sig_ok    (sig_ok),
        .fix_word  (fix_word)
    );

    // ------------------------------------------------------------------
    // outputs
    // ------------------------------------------------------------------
    always_comb begin
        busy      = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = addr_q;
        mem_wdata = '0;
        lk_ack    = 1'b0;
        lk_data   = '0;
        unique case (state)
            S_BOOT:  busy = 1'b1;
            S_IDLE:  busy = 1'b0;
            S_READ: begin
                busy    = 1'b1;
                mem_req = 1'b1;
            end
            S_WRITE: begin
                busy      = 1'b1;
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = LAST_A;
                mem_wdata = fix_word;
            end
            S_JUDGE: busy = 1'b1;
            S_REPLY: begin
                lk_ack  = 1'b1;
                lk_data = (in_range_q && valid_q) ? rd_lk : '0;
            end
            default: busy = 1'b0;
        endcase
    end

    assign valid     = valid_q;
    assign cksum_err = cerr_q;
    assign sig_err   = serr_q;
    assign board_num = valid_q ? {rd_hi, rd_lo} : '0;

endmodule

// File: rtl/nvm_ldr_checker.sv
module nvm_ldr_checker #(
    parameter int DW    = 16,
    parameter int WORDS = 64,
    parameter int AW    = 6
) (
    input logic            clk,
    input logic            rst,
    input logic            busy,
    input logic            valid,
    input logic            cksum_err,
    input logic            sig_err,
    input logic            lk_ack,
    input logic [DW-1:0]   lk_data,
    input logic            mem_req,
    input logic            mem_we,
    input logic            mem_ack,
    input logic [AW-1:0]   mem_addr,
    input logic [2*DW-1:0] board_num
);
    // R1: a pending port request keeps its address until acknowledged
    p_addr_hold_r1: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    // R3: the only write ever issued targets the last word
    p_write_last_r3: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> (mem_addr == AW'(WORDS - 1)));

    // R4: verdict flags are mutually exclusive with validity
    p_valid_clean_r4: assert property (@(posedge clk) disable iff (rst)
        valid |-> (!cksum_err && !sig_err));

    p_sig_after_sum_r4: assert property (@(posedge clk) disable iff (rst)
        sig_err |-> !cksum_err);

    // R5: answers on an invalid image are zero
    p_zero_invalid_r5: assert property (@(posedge clk) disable iff (rst)
        (lk_ack && !valid) |-> (lk_data == '0));

    // R7: board number is masked while invalid
    p_board_zero_r7: assert property (@(posedge clk) disable iff (rst)
        !valid |-> (board_num == '0));

    // R8: error flags only drop when a new operation starts
    p_cerr_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (cksum_err && !busy) |=> (cksum_err || busy));

    p_serr_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (sig_err && !busy) |=> (sig_err || busy));

    // R9: no answer while an operation is running
    p_no_ack_busy_r9: assert property (@(posedge clk) disable iff (rst)
        lk_ack |-> !busy);
endmodule

bind nvm_image_loader nvm_ldr_checker #(.DW(DW), .WORDS(WORDS), .AW(AW)) u_nvm_ldr_checker (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .valid     (valid),
    .cksum_err (cksum_err),
    .sig_err   (sig_err),
    .lk_ack    (lk_ack),
    .lk_data   (lk_data),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_ack   (mem_ack),
    .mem_addr  (mem_addr),
    .board_num (board_num)
);

// File: tb/test_nvm_image_loader.sv
module test_nvm_image_loader;
    localparam logic [15:0] TGT  = 16'hBABA;
    localparam logic [15:0] MASK = 16'hC000;
    localparam logic [15:0] SIGV = 16'h4000;
    localparam int          CTRL = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load_req = 1'b0, upd_req = 1'b0, lk_req = 1'b0;
    logic [6:0]  lk_idx = '0;
    logic        lk_ack;
    logic [15:0] lk_data;
    logic        mem_req, mem_we, mem_ack = 1'b0;
    logic [5:0]  mem_addr;
    logic [15:0] mem_wdata, mem_rdata = '0;
    logic        busy, valid, cksum_err, sig_err;
    logic [31:0] board_num;

    always #5 clk = ~clk;

    nvm_image_loader i_nvm_image_loader (
        .clk(clk), .rst(rst), .load_req(load_req), .upd_req(upd_req),
        .lk_req(lk_req), .lk_idx(lk_idx), .lk_ack(lk_ack), .lk_data(lk_data),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .busy(busy), .valid(valid), .cksum_err(cksum_err), .sig_err(sig_err),
        .board_num(board_num)
    );

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ---------------- memory model behind the word port ----------------
    logic [15:0] img [64];
    int          rd_cnt = 0;
    int          wr_cnt = 0;
    int          last_wr_addr = -1;
    int          rd_log [$];

    always @(posedge clk) begin
        if (rst) begin
            mem_ack <= 1'b0;
        end else begin
            mem_ack <= mem_req && !mem_ack;
            if (mem_req && !mem_ack) begin
                if (mem_we) begin
                    img[mem_addr] <= mem_wdata;
                    wr_cnt       <= wr_cnt + 1;
                    last_wr_addr <= int'(mem_addr);
                end else begin
                    mem_rdata <= img[mem_addr];
                    rd_cnt    <= rd_cnt + 1;
                    rd_log.push_back(int'(mem_addr));
                end
            end
        end
    end

    function automatic logic [15:0] sum_to(input int n);
        logic [15:0] s = '0;
        for (int i = 0; i < n; i++) s = s + img[i];
        return s;
    endfunction

    task automatic prep_good();
        for (int i = 0; i < 63; i++) img[i] = 16'(i * 16'h0357 + 16'h91C3);
        img[CTRL] = (img[CTRL] & ~MASK) | SIGV;
        img[63]   = TGT - sum_to(63);
    endtask

    // ---------------- scoreboard for lookup answers --------------------
    logic [15:0] exp_q [$];
    string       tag_q [$];

    always @(negedge clk) begin
        if (!rst && lk_ack) begin
            chk("R9 answer while busy", 32'(busy), 32'd0);
            if (exp_q.size() == 0) begin
                chk("R5 unexpected answer", 32'(lk_ack), 32'd0);
            end else begin
                chk(tag_q.pop_front(), 32'(lk_data), 32'(exp_q.pop_front()));
            end
        end
    end

    task automatic lookup(input logic [6:0] idx, input logic [15:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        lk_req = 1'b1;
        lk_idx = idx;
        do @(negedge clk); while (!lk_ack);
        lk_req = 1'b0;
    endtask

    task automatic pulse(input bit upd);
        @(negedge clk);
        if (upd) upd_req = 1'b1; else load_req = 1'b1;
        @(negedge clk);
        upd_req  = 1'b0;
        load_req = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int r0, w0;
        logic [15:0] fix;
        prep_good();
        repeat (3) @(negedge clk);
        chk("R8 reset valid", 32'(valid), 0);
        chk("R8 reset cksum_err", 32'(cksum_err), 0);
        chk("R8 reset sig_err", 32'(sig_err), 0);
        chk("R1 reset mem_req", 32'(mem_req), 0);
        chk("R5 reset lk_ack", 32'(lk_ack), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 busy after reset", 32'(busy), 1);
        wait_idle();

        // R1: automatic load, ascending order
        chk("R1 read count", 32'(rd_log.size()), 64);
        for (int i = 0; i < 64 && i < rd_log.size(); i++)
            chk("R1 read order", 32'(rd_log[i]), 32'(i));
        chk("R2 valid good image", 32'(valid), 1);
        chk("R2 no cksum_err", 32'(cksum_err), 0);
        chk("R4 no sig_err", 32'(sig_err), 0);
        chk("R7 board number", board_num, {img[9], img[8]});

        // R5/R6: lookups on a valid image, no port traffic
        r0 = rd_cnt;
        lookup(7'd0,   img[0],  "R5 idx 0");
        lookup(7'd5,   img[5],  "R5 idx 5");
        lookup(7'd63,  img[63], "R5 idx 63");
        lookup(7'd64,  16'h0,   "R5 idx 64");
        lookup(7'd127, 16'h0,   "R5 idx 127");
        chk("R6 no reads when valid", 32'(rd_cnt - r0), 0);

        // R2: corrupted image
        img[20] = img[20] ^ 16'h00F0;
        pulse(1'b0);
        wait_idle();
        chk("R2 cksum_err set", 32'(cksum_err), 1);
        chk("R2 valid low", 32'(valid), 0);
        chk("R4 sig_err low on sum fail", 32'(sig_err), 0);
        chk("R7 board zero when invalid", board_num, 0);

        // R6: out-of-range lookup never reloads; R8 flag holds
        r0 = rd_cnt;
        lookup(7'd70, 16'h0, "R5 out of range invalid");
        chk("R6 no reload out of range", 32'(rd_cnt - r0), 0);
        chk("R8 cksum_err held", 32'(cksum_err), 1);
        lookup(7'd3, 16'h0, "R6 reload still invalid");
        chk("R6 reload read count", 32'(rd_cnt - r0), 64);

        // R3: repair
        fix = TGT - sum_to(63);
        r0 = rd_cnt;
        w0 = wr_cnt;
        pulse(1'b1);
        chk("R8 cksum_err cleared at start", 32'(cksum_err), 0);
        chk("R8 valid low during op", 32'(valid), 0);
        wait_idle();
        chk("R3 reads 63 words", 32'(rd_cnt - r0), 63);
        chk("R3 one write", 32'(wr_cnt - w0), 1);
        chk("R3 write address", 32'(last_wr_addr), 63);
        chk("R3 written word", 32'(img[63]), 32'(fix));
        chk("R3 valid after repair", 32'(valid), 1);
        lookup(7'd63, fix, "R3 shadow word 63");

        // R4: signature wrong, checksum repaired
        img[CTRL] = img[CTRL] & ~MASK;
        pulse(1'b1);
        wait_idle();
        chk("R4 sig_err set", 32'(sig_err), 1);
        chk("R4 cksum_err low", 32'(cksum_err), 0);
        chk("R4 valid low", 32'(valid), 0);
        lookup(7'd2, 16'h0, "R4 lookup zero on bad signature");
        chk("R8 sig_err held", 32'(sig_err), 1);

        // R6: repaired image, lookup reloads then answers
        prep_good();
        r0 = rd_cnt;
        lookup(7'd7, img[7], "R6 reload then answer");
        chk("R6 reload count", 32'(rd_cnt - r0), 64);
        chk("R6 valid after reload", 32'(valid), 1);
        chk("R8 sig_err cleared", 32'(sig_err), 0);

        // R9: lookup raised during a load stalls
        r0 = rd_cnt;
        pulse(1'b0);
        chk("R9 busy when lookup raised", 32'(busy), 1);
        lookup(7'd11, img[11], "R9 stalled lookup");
        chk("R9 single load", 32'(rd_cnt - r0), 64);

        repeat (4) @(negedge clk);
        chk("R5 scoreboard drained", 32'(exp_q.size()), 0);
        finish_run();
    end
endmodule